// File: doc/BRIEF.md
# Static Memory Bank Configuration Register File

This block is the software-visible settings store of an external static memory controller. It sits on a simple 32-bit peripheral bus and holds, for each of eight memory banks, the idle gap between accesses, two wait-state counts, the delays of the output and write enables after chip select, a control byte and a set of sticky error flags. Its configuration buses drive a memory access sequencer directly. That sequencer in turn reports errors and the live external wait level back to this block.

Each bank owns seven consecutive 32-bit words beginning at byte offset 0x1C times the bank index. Just above the last bank's words is a read-only word that reports the external wait level, but only after an externally waited transfer was cut short. The upper end of the 4 KB window holds eight read-only identification bytes. The memory width of the highest bank comes from a 2-bit strap at reset, so a boot device of any width can be placed in that bank. Error flags are set by one-cycle pulses from the sequencer. Software clears a flag by writing 1 to its bit.

Top module: `smc_bank_regfile`

## Requirements
- R1: After reset every bank reads idle = 0xF (word 0), read wait = 0x1F (word 1), write/burst wait = 0x1F (word 2), OE delay = 0x0 (word 3), WE delay = 0x1 (word 4) and status = 0 (word 6). Bank b's word k is at byte offset 0x1C*b + 4*k.
- R2: After reset the control word (word 5) of each bank is zero except for the width field in bits [7:6]. The reset width for banks 0..6 is 32, 8, 16, 8, 32, 32, 16 bits, encoded 00 = 8-bit, 01 = 16-bit, 10 = 32-bit. For bank 7 the width is the value on `mw_strap_i` while reset is asserted.
- R3: Words 0..5 of each bank are read/write with widths 4, 5, 5, 4, 4 and 8 bits. Bits above a field's width read as zero and written values do not store in them.
- R4: A bus write reaches only the one bank word it addresses, and writes to other banks leave that word unchanged.
- R5: In status word 6 (bit 2 wait timeout, bit 1 write protect, bit 0 transfer size), writing 1 to a bit clears it. Writing 0 to a bit leaves it unchanged, and a written 1 never sets a bit.
- R6: A one-cycle pulse on `err_set_i[3*b+k]` sets status bit k of bank b. If the pulse arrives in the same cycle as a software clear of that bit, the bit stays set.
- R7: The word at 0xE0 is read-only. Its bit 0 equals `ext_wait_i` from the cycle after a pulse on `wait_cut_i` until the first cycle in which `ext_wait_i` is low. At all other times it reads 0, and all of its other bits read 0.
- R8: The words at 0xFE0, 0xFE4, ... 0xFFC read 0x92, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits [7:0] with zero above, and writes do not change them.
- R9: Reads from offsets that are not mapped (0xE4 to 0xFDC) return zero, and writes to them change no register.
- R10: The per-bank configuration outputs always equal the contents of the corresponding bank words, packed with bank b in slice [b*W +: W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mw_strap_i | input | 2 | Reset memory width of the highest bank |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address within the 4 KB window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| err_set_i | input | 24 | Error set pulses, bank b bit k at 3*b+k |
| wait_cut_i | input | 1 | Pulse: an externally waited transfer ended early |
| ext_wait_i | input | 1 | Live external wait level, active high |
| idle_o | output | 32 | Idle cycles, 4 bits per bank |
| wait_rd_o | output | 40 | Read wait states, 5 bits per bank |
| wait_wr_o | output | 40 | Write/burst wait states, 5 bits per bank |
| oe_dly_o | output | 32 | OE delay, 4 bits per bank |
| we_dly_o | output | 32 | WE delay, 4 bits per bank |
| ctrl_o | output | 64 | Control byte, 8 bits per bank |
| stat_o | output | 24 | Status flags, 3 bits per bank |

## Verification
The assertions assume that `err_set_i` and `wait_cut_i` are one-cycle pulses driven between clock edges, and that a bus write lasts one clock with a stable address. The bench drives every input on the falling edge and pulses each error bit or wait cut for exactly one cycle. It performs writes as single-cycle strobes and reads with the strobe low at the clock edge, so the write-path assertions see only intended writes. The assertion on unmapped reads assumes the address is held through the sampling edge, and the bench keeps each read address steady until the next falling edge.

// File: rtl/smc_cfg_pkg.sv
// Package: shared constants, slot encoding and reset tables for the
// static memory bank register file. Assumes eight-bank reset table
// repeats if more banks are configured.
package smc_cfg_pkg;

    localparam int REGS_PER_BANK = 7;
    localparam int IDLE_W        = 4;
    localparam int WAIT_W        = 5;
    localparam int DLY_W         = 4;
    localparam int CTRL_W        = 8;
    localparam int STAT_W        = 3;
    localparam int ID_BYTES      = 8;

    // Word slot inside one bank; order is fixed by the address map.
    typedef enum logic [2:0] {
        SLOT_IDLE    = 3'd0,
        SLOT_WAIT_RD = 3'd1,
        SLOT_WAIT_WR = 3'd2,
        SLOT_OE      = 3'd3,
        SLOT_WE      = 3'd4,
        SLOT_CTRL    = 3'd5,
        SLOT_STAT    = 3'd6
    } slot_e;

    localparam logic [1:0] MW_8  = 2'b00;
    localparam logic [1:0] MW_16 = 2'b01;
    localparam logic [1:0] MW_32 = 2'b10;

    // Reset width field for a bank that does not take the strap.
    function automatic logic [1:0] reset_width(input int idx);
        case (idx % 8)
            0, 4, 5: reset_width = MW_32;
            2, 6:    reset_width = MW_16;
            default: reset_width = MW_8;
        endcase
    endfunction

    // Identification byte k (0..7) of the top of the window.
    function automatic logic [7:0] id_byte(input int k);
        case (k)
            0:       id_byte = 8'h92;
            1:       id_byte = 8'h10;
            2:       id_byte = 8'h04;
            3:       id_byte = 8'h00;
            4:       id_byte = 8'h0D;
            5:       id_byte = 8'hF0;
            6:       id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/smc_bank_regs.sv
// Module: one bank's seven configuration words. Decodes its own word
// range, holds timing, control and sticky status fields, and returns
// read data (zero when not addressed). Assumes err_set is a pulse and
// the bus write strobe lasts one clock.
module smc_bank_regs
    import smc_cfg_pkg::*;
#(
    parameter int BANK_IDX = 0,
    parameter int WORD_W   = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   word_idx,
    input  logic [7:0]          wdata,
    input  logic [1:0]          rst_mw,
    input  logic [STAT_W-1:0]   err_set,
    output logic [31:0]         rd_data,
    output logic [IDLE_W-1:0]   idle_o,
    output logic [WAIT_W-1:0]   wait_rd_o,
    output logic [WAIT_W-1:0]   wait_wr_o,
    output logic [DLY_W-1:0]    oe_dly_o,
    output logic [DLY_W-1:0]    we_dly_o,
    output logic [CTRL_W-1:0]   ctrl_o,
    output logic [STAT_W-1:0]   stat_o
);

    localparam logic [WORD_W-1:0] BASE = WORD_W'(BANK_IDX * REGS_PER_BANK);
    localparam logic [WORD_W-1:0] LAST = WORD_W'(BANK_IDX * REGS_PER_BANK + REGS_PER_BANK - 1);

    logic              hit;
    logic [WORD_W-1:0] offs;
    slot_e             slot;
    logic              wr_hit;
    logic              stat_wr;
    logic [STAT_W-1:0] stat_clr;

    logic [IDLE_W-1:0] idle_q;
    logic [WAIT_W-1:0] wrd_q;
    logic [WAIT_W-1:0] wwr_q;
    logic [DLY_W-1:0]  oe_q;
    logic [DLY_W-1:0]  we_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [STAT_W-1:0] stat_q;

    // Address decode of this bank's word range.
    always_comb begin
        hit  = (word_idx >= BASE) && (word_idx <= LAST);
        offs = word_idx - BASE;
        slot = slot_e'(offs[2:0]);
    end

    assign wr_hit   = wr_en && hit;
    assign stat_wr  = wr_hit && (slot == SLOT_STAT);
    assign stat_clr = stat_wr ? wdata[STAT_W-1:0] : '0;

    // Timing and control fields: reset defaults, then bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= '1;
            wrd_q  <= '1;
            wwr_q  <= '1;
            oe_q   <= '0;
            we_q   <= DLY_W'(1);
            ctrl_q <= {rst_mw, 6'b0};
        end else if (wr_hit) begin
            case (slot)
                SLOT_IDLE:    idle_q <= wdata[IDLE_W-1:0];
                SLOT_WAIT_RD: wrd_q  <= wdata[WAIT_W-1:0];
                SLOT_WAIT_WR: wwr_q  <= wdata[WAIT_W-1:0];
                SLOT_OE:      oe_q   <= wdata[DLY_W-1:0];
                SLOT_WE:      we_q   <= wdata[DLY_W-1:0];
                SLOT_CTRL:    ctrl_q <= wdata[CTRL_W-1:0];
                default:      ;
            endcase
        end
    end

    // Sticky error flags: hardware set outranks software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~stat_clr) | err_set;
    end

    // Read data for the addressed word, zero elsewhere.
    always_comb begin
        rd_data = '0;
        if (hit) begin
            case (slot)
                SLOT_IDLE:    rd_data = 32'(idle_q);
                SLOT_WAIT_RD: rd_data = 32'(wrd_q);
                SLOT_WAIT_WR: rd_data = 32'(wwr_q);
                SLOT_OE:      rd_data = 32'(oe_q);
                SLOT_WE:      rd_data = 32'(we_q);
                SLOT_CTRL:    rd_data = 32'(ctrl_q);
                SLOT_STAT:    rd_data = 32'(stat_q);
                default:      rd_data = '0;
            endcase
        end
    end

    assign idle_o    = idle_q;
    assign wait_rd_o = wrd_q;
    assign wait_wr_o = wwr_q;
    assign oe_dly_o  = oe_q;
    assign we_dly_o  = we_q;
    assign ctrl_o    = ctrl_q;
    assign stat_o    = stat_q;

    AST_RESET_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (idle_q == 4'hF && wrd_q == 5'h1F && wwr_q == 5'h1F
                          && oe_q == 4'h0 && we_q == 4'h1 && stat_q == 3'b0)); // R1
    AST_RESET_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctrl_q[5:0] == 6'b0)); // R2
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> ($stable(idle_q) && $stable(wrd_q) && $stable(wwr_q)
                     && $stable(oe_q) && $stable(we_q) && $stable(ctrl_q))); // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_set) |=> ((stat_q & $past(err_set)) == $past(err_set))); // R6
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && err_set == '0) |=> ((stat_q & $past(wdata[STAT_W-1:0])) == '0)); // R5
    AST_W0_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(stat_q & ~stat_clr)) == $past(stat_q & ~stat_clr))); // R5

endmodule

// File: rtl/smc_ext_wait.sv
// Module: tracks the window after an early-ended waited transfer and
// reports the live wait level only inside that window. Assumes
// ext_wait is already active-high and synchronous to clk.
module smc_ext_wait (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_cut,
    input  logic ext_wait,
    output logic status
);

    logic trk_q;

    // Window opens on a cut pulse and closes once wait is seen low.
    always_ff @(posedge clk) begin
        if (!rst_n)         trk_q <= 1'b0;
        else if (wait_cut)  trk_q <= 1'b1;
        else if (!ext_wait) trk_q <= 1'b0;
    end

    assign status = trk_q & ext_wait;

    AST_WAIT_DROP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_wait && !wait_cut) |=> !status); // R7
    AST_CUT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cut |=> (status == ext_wait)); // R7

endmodule

// File: rtl/smc_id_rom.sv
// Module: read-only identification bytes in the last eight words of
// the window. Assumes ADDR_W leaves room for them above the banks.
module smc_id_rom
    import smc_cfg_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic [WORD_W-1:0] word_idx,
    output logic [31:0]       rd_data
);

    localparam logic [WORD_W-1:0] ID_BASE = WORD_W'((1 << WORD_W) - ID_BYTES);

    logic [ID_BYTES-1:0][7:0] rom;

    // Build the constant byte table from the package.
    for (genvar k = 0; k < ID_BYTES; k++) begin : g_id
        assign rom[k] = id_byte(k);
    end

    // Select the byte for an address in the ID range.
    always_comb begin
        rd_data = '0;
        if (word_idx >= ID_BASE)
            rd_data = {24'b0, rom[word_idx[2:0]]};
    end

endmodule

// File: rtl/smc_bank_regfile.sv
// Module: top of the static memory bank register file. Decodes the bus
// word address, instantiates one register set per bank, the external
// wait status word and the ID bytes, and ORs their read data.
// Assumes word-aligned accesses; the two low address bits are ignored.
module smc_bank_regfile
    import smc_cfg_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ADDR_W    = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   mw_strap_i,
    input  logic                         bus_sel_i,
    input  logic                         bus_wr_i,
    input  logic [ADDR_W-1:0]            bus_addr_i,
    input  logic [31:0]                  bus_wdata_i,
    output logic [31:0]                  bus_rdata_o,
    input  logic [NUM_BANKS*STAT_W-1:0]  err_set_i,
    input  logic                         wait_cut_i,
    input  logic                         ext_wait_i,
    output logic [NUM_BANKS*IDLE_W-1:0]  idle_o,
    output logic [NUM_BANKS*WAIT_W-1:0]  wait_rd_o,
    output logic [NUM_BANKS*WAIT_W-1:0]  wait_wr_o,
    output logic [NUM_BANKS*DLY_W-1:0]   oe_dly_o,
    output logic [NUM_BANKS*DLY_W-1:0]   we_dly_o,
    output logic [NUM_BANKS*CTRL_W-1:0]  ctrl_o,
    output logic [NUM_BANKS*STAT_W-1:0]  stat_o
);

    localparam int WORD_W                 = ADDR_W - 2;
    localparam logic [WORD_W-1:0] EWS_WORD = WORD_W'(NUM_BANKS * REGS_PER_BANK);
    localparam logic [WORD_W-1:0] ID_BASE  = WORD_W'((1 << WORD_W) - ID_BYTES);

    logic [WORD_W-1:0] word_idx;
    logic              wr_en;
    logic              ews_bit;
    logic [31:0]       id_rd;
    logic [31:0]       bank_rd [NUM_BANKS];
    logic              unused_bits;

    assign word_idx    = bus_addr_i[ADDR_W-1:2];
    assign wr_en       = bus_sel_i && bus_wr_i;
    assign unused_bits = ^{bus_addr_i[1:0], bus_wdata_i[31:8]};

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [1:0] rst_mw;
        if (b == NUM_BANKS - 1) begin : g_strap
            assign rst_mw = mw_strap_i;
        end else begin : g_fixed
            assign rst_mw = reset_width(b);
        end

        smc_bank_regs #(
            .BANK_IDX (b),
            .WORD_W   (WORD_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_en),
            .word_idx  (word_idx),
            .wdata     (bus_wdata_i[7:0]),
            .rst_mw    (rst_mw),
            .err_set   (err_set_i[b*STAT_W +: STAT_W]),
            .rd_data   (bank_rd[b]),
            .idle_o    (idle_o[b*IDLE_W +: IDLE_W]),
            .wait_rd_o (wait_rd_o[b*WAIT_W +: WAIT_W]),
            .wait_wr_o (wait_wr_o[b*WAIT_W +: WAIT_W]),
            .oe_dly_o  (oe_dly_o[b*DLY_W +: DLY_W]),
            .we_dly_o  (we_dly_o[b*DLY_W +: DLY_W]),
            .ctrl_o    (ctrl_o[b*CTRL_W +: CTRL_W]),
            .stat_o    (stat_o[b*STAT_W +: STAT_W])
        );
    end

    smc_ext_wait u_ews (
        .clk      (clk),
        .rst_n    (rst_n),
        .wait_cut (wait_cut_i),
        .ext_wait (ext_wait_i),
        .status   (ews_bit)
    );

    smc_id_rom #(.WORD_W(WORD_W)) u_id (
        .word_idx (word_idx),
        .rd_data  (id_rd)
    );

    // Combine read sources; each returns zero when not addressed.
    always_comb begin
        bus_rdata_o = id_rd;
        if (word_idx == EWS_WORD) bus_rdata_o[0] = ews_bit;
        for (int b = 0; b < NUM_BANKS; b++) bus_rdata_o = bus_rdata_o | bank_rd[b];
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (word_idx > EWS_WORD && word_idx < ID_BASE) |-> (bus_rdata_o == 32'b0)); // R9
    AST_EWS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (word_idx == EWS_WORD) |-> (bus_rdata_o[31:1] == 31'b0)); // R7

endmodule

// File: tb/smc_bank_regfile_bench.sv
module smc_bank_regfile_bench;

    localparam int NB = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mw_strap = 2'b01;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NB*3-1:0] err_set = '0;
    logic        wait_cut = 1'b0;
    logic        ext_wait = 1'b0;
    logic [NB*4-1:0] idle_o, oe_o, we_o;
    logic [NB*5-1:0] wrd_o, wwr_o;
    logic [NB*8-1:0] ctrl_o;
    logic [NB*3-1:0] stat_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    smc_bank_regfile u_smc_bank_regfile (
        .clk(clk), .rst_n(rst_n), .mw_strap_i(mw_strap),
        .bus_sel_i(bus_sel), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .err_set_i(err_set), .wait_cut_i(wait_cut), .ext_wait_i(ext_wait),
        .idle_o(idle_o), .wait_rd_o(wrd_o), .wait_wr_o(wwr_o),
        .oe_dly_o(oe_o), .we_dly_o(we_o), .ctrl_o(ctrl_o), .stat_o(stat_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [11:0] baddr(input int b, input int k);
        return 12'(b * 28 + k * 4);
    endfunction

    function automatic logic [31:0] fmask(input int k);
        case (k)
            0, 3, 4: return 32'h0F;
            1, 2:    return 32'h1F;
            5:       return 32'hFF;
            default: return 32'h07;
        endcase
    endfunction

    function automatic logic [31:0] out_field(input int b, input int k);
        case (k)
            0: return 32'(idle_o[b*4 +: 4]);
            1: return 32'(wrd_o[b*5 +: 5]);
            2: return 32'(wwr_o[b*5 +: 5]);
            3: return 32'(oe_o[b*4 +: 4]);
            4: return 32'(we_o[b*4 +: 4]);
            5: return 32'(ctrl_o[b*8 +: 8]);
            default: return 32'(stat_o[b*3 +: 3]);
        endcase
    endfunction

    // R1 R2 R10: reset values, including the strapped bank.
    task automatic t_reset;
        logic [31:0] d;
        logic [1:0] mw [8] = '{2'b10, 2'b00, 2'b01, 2'b00, 2'b10, 2'b10, 2'b01, 2'b01};
        logic [31:0] exp [7] = '{32'hF, 32'h1F, 32'h1F, 32'h0, 32'h1, 32'h0, 32'h0};
        for (int b = 0; b < NB; b++) begin
            for (int k = 0; k < 7; k++) begin
                logic [31:0] e;
                e = (k == 5) ? {24'b0, mw[b], 6'b0} : exp[k];
                bus_read(baddr(b, k), d);
                check((k == 5) ? "R2 reset ctrl" : "R1 reset word", d, e);
                check("R10 reset output", out_field(b, k), e);
            end
        end
    endtask

    // R3 R4 R10: write then read back every field with two patterns.
    task automatic t_fields;
        logic [31:0] d;
        for (int p = 0; p < 2; p++) begin
            for (int b = 0; b < NB; b++)
                for (int k = 0; k < 6; k++)
                    bus_write(baddr(b, k), (p == 0) ? 32'hFFFF_FFFF : 32'(32'h5A3C_6900 + b * 7 + k * 3));
            for (int b = 0; b < NB; b++)
                for (int k = 0; k < 6; k++) begin
                    logic [31:0] e;
                    e = ((p == 0) ? 32'hFFFF_FFFF : 32'(32'h5A3C_6900 + b * 7 + k * 3)) & fmask(k);
                    bus_read(baddr(b, k), d);
                    check("R3 R4 readback", d, e);
                    check("R10 output", out_field(b, k), e);
                end
        end
    endtask

    // R5 R6: sticky error flags, write-one-to-clear and set priority.
    task automatic t_status;
        logic [31:0] d;
        for (int b = 0; b < NB; b++) begin
            @(negedge clk); err_set[b*3 +: 3] = 3'b111;
            @(negedge clk); err_set = '0;
            bus_read(baddr(b, 6), d);
            check("R6 set pulse", d, 32'h7);
            bus_write(baddr(b, 6), 32'h0);
            bus_read(baddr(b, 6), d);
            check("R5 write zero keeps", d, 32'h7);
            bus_write(baddr(b, 6), 32'h2);
            bus_read(baddr(b, 6), d);
            check("R5 clear bit1", d, 32'h5);
            @(negedge clk);
            bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = baddr(b, 6); bus_wdata = 32'h5;
            err_set[b*3] = 1'b1;
            @(negedge clk);
            bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; err_set = '0;
            bus_read(baddr(b, 6), d);
            check("R6 set beats clear", d, 32'h1);
            bus_write(baddr(b, 6), 32'h7);
            bus_read(baddr(b, 6), d);
            check("R5 all cleared", d, 32'h0);
            check("R10 stat output", out_field(b, 6), 32'h0);
        end
    endtask

    // R7: external wait status word.
    task automatic t_ext_wait;
        logic [31:0] d;
        @(negedge clk); ext_wait = 1'b1;
        bus_read(12'h0E0, d);
        check("R7 no window", d, 32'h0);
        @(negedge clk); wait_cut = 1'b1;
        @(negedge clk); wait_cut = 1'b0;
        bus_read(12'h0E0, d);
        check("R7 window live", d, 32'h1);
        bus_write(12'h0E0, 32'h0);
        bus_read(12'h0E0, d);
        check("R7 write ignored", d, 32'h1);
        @(negedge clk); ext_wait = 1'b0;
        #1 check("R7 wait low", bus_rdata, 32'h0);
        @(negedge clk); ext_wait = 1'b1;
        bus_read(12'h0E0, d);
        check("R7 window closed", d, 32'h0);
        ext_wait = 1'b0;
    endtask

    // R8: identification bytes, and writes to them.
    task automatic t_id;
        logic [31:0] d;
        logic [7:0] idb [8] = '{8'h92, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int k = 0; k < 8; k++) begin
            bus_write(12'(12'hFE0 + k * 4), 32'hFFFF_FFFF);
            bus_read(12'(12'hFE0 + k * 4), d);
            check("R8 id byte", d, {24'b0, idb[k]});
        end
    endtask

    // R9: unmapped offsets read zero and writes touch nothing.
    task automatic t_unmapped;
        logic [31:0] d;
        logic [11:0] holes [4] = '{12'h0E4, 12'h100, 12'h800, 12'hFDC};
        bus_write(baddr(0, 0), 32'h6);
        for (int i = 0; i < 4; i++) begin
            bus_write(holes[i], 32'hFFFF_FFFF);
            bus_read(holes[i], d);
            check("R9 unmapped read", d, 32'h0);
        end
        bus_read(baddr(0, 0), d);
        check("R9 bank word untouched", d, 32'h6);
        bus_read(baddr(7, 5), d);
        check("R9 ctrl untouched", d, 32'(32'h5A3C_6900 + 49 + 15) & 32'hFF);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        mw_strap = 2'b10;
        t_reset();
        t_fields();
        t_status();
        t_ext_wait();
        t_id();
        t_unmapped();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule